// File: doc/BRIEF.md
# Weighted Thread Slot Scheduler

This block decides, on every system clock, which one of eight hardware threads may issue an instruction. Time is cut into frames of sixteen slots. A 3-bit mode picks one of eight fixed slot tables, and each table gives every thread a fixed, unequal or equal share of the clock. A thread's instruction rate is therefore the clock rate times its share, and the share is enforced in hardware with no software task switching.

An 8-bit enable mask marks the threads in use. A slot owned by a disabled thread becomes an idle cycle and is never handed to another thread, so the slot positions of the enabled threads do not move when the mask changes. The mode input is sampled only at the end of a frame, so a new mode never splits a frame.

Top module: `thread_slot_sched`

## Requirements
- R1: A slot counter counts 0 to 15 and wraps to 0, advancing one per clock. A synchronous active-low reset returns it to 0 from any point in the frame, and the frame after reset uses the mode present during reset.
- R2: Mode 0 gives thread 0 eight slots, thread 1 two slots and threads 2 to 7 one slot each per frame. Thread 0 owns every even slot.
- R3: Mode 1 gives threads 0 and 1 four slots each, threads 2 and 3 two each and threads 4 to 7 one each.
- R4: Mode 2 gives each thread two slots, with slot s owned by thread s mod 8.
- R5: Modes 3 to 7 use fixed tables. Slots per frame for threads 0 to 7 are 8,2,2,2,2,0,0,0 in mode 3; 4,4,4,2,2,0,0,0 in mode 4; 1,4,4,4,1,1,1,0 in mode 5; 1,8,2,1,1,1,1,1 in mode 6; and 2,8,2,2,2,0,0,0 in mode 7.
- R6: Every slot of every mode has an owner, so with all threads enabled an issue happens on every clock.
- R7: The slots of a thread with n slots per frame sit exactly 16/n slots apart.
- R8: When the owner of a slot has its enable bit clear, the issue vector is all zero for that slot. The thread index still shows the owner, and the slots of enabled threads are unchanged.
- R9: The issue vector is one-hot or zero. When it is non-zero, its set bit is the bit numbered by the thread index.
- R10: The mode input is taken at the clock edge that ends slot 15, and the new table applies from the next slot 0. Changes made and undone within a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Requested slot table |
| en_i | input | 8 | Thread enable mask, bit t for thread t |
| issue_o | output | 8 | One-hot issue grant, zero in an idle slot |
| tid_o | output | 3 | Owner of the current slot |

## Verification
On every cycle, the assertions check several properties. The issue vector must be one-hot or zero and must agree with the thread index, and no disabled thread may ever be granted. The counter must wrap after slot 15, the active table must hold steady inside a frame, and thread 0 must own the even slots in mode 0. All slots must be granted when the mask is full. The per-mode shares and the even spacing are shown only by the bench's sweeps over all eight modes. The same holds for the unchanged slot layout under many masks and for mode changes made mid-frame, in the last slot, and made and undone within one frame.

// File: rtl/thread_slot_sched.sv
module thread_slot_sched #(
  parameter int THREADS = 8,
  parameter int FRAME   = 16,
  parameter int MODES   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(MODES)-1:0]   mode_i,
  input  logic [THREADS-1:0]         en_i,
  output logic [THREADS-1:0]         issue_o,
  output logic [$clog2(THREADS)-1:0] tid_o
);
  localparam int TW = $clog2(THREADS);
  localparam int SW = $clog2(FRAME);
  localparam int MW = $clog2(MODES);
  localparam logic [SW-1:0] LAST = SW'(FRAME - 1);

  logic [SW-1:0] slot;
  logic [MW-1:0] act_mode;

  function automatic logic [2:0] owner(input logic [2:0] m, input logic [3:0] s);
    logic [2:0] k, j, idx;
    k   = s[3:1];
    j   = {s[3:2], s[1]};
    idx = (k[2] ? 3'd3 : 3'd0) + {1'b0, k[1:0]} - 3'd1;
    case (m)
      3'd0: owner = !s[0] ? 3'd0 : (k[1:0] == 2'd0) ? 3'd1 : idx + 3'd2;
      3'd1: begin
        if (s[1:0] == 2'd0)      owner = 3'd0;
        else if (s[1:0] == 2'd2) owner = 3'd1;
        else if (!j[0])          owner = j[1] ? 3'd3 : 3'd2;
        else                     owner = 3'd4 + {1'b0, j[2], j[1]};
      end
      3'd2: owner = s[2:0];
      3'd3: owner = !s[0] ? 3'd0 : 3'd1 + {1'b0, s[2:1]};
      3'd4: owner = (s[1:0] != 2'd3) ? {1'b0, s[1:0]} : 3'd3 + {2'b0, s[2]};
      3'd5: owner = (s[1:0] != 2'd0) ? {1'b0, s[1:0]} :
                    (s[3:2] == 2'd0) ? 3'd0 : 3'd3 + {1'b0, s[3:2]};
      3'd6: owner = s[0] ? 3'd1 : (k[1:0] == 2'd0) ? 3'd2 :
                    (idx == 3'd0) ? 3'd0 : idx + 3'd2;
      default: owner = s[0] ? 3'd1 : (s[2:1] == 2'd0) ? 3'd0 : {1'b0, s[2:1]} + 3'd1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      act_mode <= mode_i;
    end else begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
      if (slot == LAST) act_mode <= mode_i;
    end
  end

  assign tid_o   = TW'(owner(3'(act_mode), 4'(slot)));
  assign issue_o = en_i[tid_o] ? (THREADS'(1) << tid_o) : '0;

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_o));
  p_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o != '0) |-> issue_o[tid_o]);
  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o & ~en_i) == '0);
  p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '1) |-> (issue_o != '0));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST) |=> (slot == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != '0) |-> $stable(act_mode));
  p_even0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == '0 && !slot[0]) |-> (tid_o == '0));
endmodule

// File: tb/thread_slot_sched_tb_top.sv
module thread_slot_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] en = 8'hFF;
  logic [7:0] issue;
  logic [2:0] tid;
  int checks = 0;
  int fails = 0;
  int idx = 0;
  logic [2:0] ref_tid [16];

  thread_slot_sched dut_i (.clk(clk), .rst_n(rst_n), .mode_i(mode), .en_i(en),
                           .issue_o(issue), .tid_o(tid));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int share(input int m, input int t);
    logic [31:0] v;
    case (m)
      0: v = 32'h11111128;
      1: v = 32'h11112244;
      2: v = 32'h22222222;
      3: v = 32'h00022228;
      4: v = 32'h00022444;
      5: v = 32'h01114441;
      6: v = 32'h11111281;
      default: v = 32'h00022282;
    endcase
    return int'(v[4*t +: 4]);
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
    idx++;
  endtask

  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 1'b0;
    mode = 3'(m);
    en = 8'hFF;
    repeat (2) @(negedge clk);
    #1;
    if (m == 2) chk(tid == 3'd0, "R1 slot 0 in reset", tid, 0);
    rst_n = 1'b1;
    idx = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      int cnt [8];
      int first [8];
      string rq;
      rq = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
      do_reset(m);
      for (int t = 0; t < 8; t++) begin cnt[t] = 0; first[t] = -1; end
      for (int s = 0; s < 16; s++) begin
        ref_tid[s] = tid;
        chk(issue == (8'd1 << tid), "R6 R9 every slot granted", issue, 1 << tid);
        if (m == 2) chk(tid == 3'(s % 8), "R4 slot owner", tid, s % 8);
        if (m == 0 && s % 2 == 0) chk(tid == 3'd0, "R2 even slot", tid, 0);
        cnt[tid]++;
        if (first[tid] < 0) first[tid] = s;
        step();
      end
      for (int t = 0; t < 8; t++) begin
        chk(cnt[t] == share(m, t), rq, cnt[t], share(m, t));
        if (cnt[t] > 0) begin
          int bad;
          bad = 0;
          for (int s = 0; s < 16; s++)
            if (ref_tid[s] == 3'(t) && ((s - first[t]) % (16 / cnt[t])) != 0) bad++;
          chk(bad == 0, "R7 even spacing", bad, 0);
        end
      end
      for (int q = 0; q < 7; q++) begin
        logic [7:0] mk;
        case (q)
          0: mk = 8'h00;
          1: mk = 8'h55;
          2: mk = 8'hAA;
          3: mk = 8'h0F;
          4: mk = 8'hF0;
          5: mk = 8'd1 << m;
          default: mk = ~(8'd1 << m);
        endcase
        for (int s = 0; s < 16; s++) begin
          logic [7:0] ex;
          en = mk;
          #1;
          ex = mk[ref_tid[s]] ? (8'd1 << ref_tid[s]) : 8'd0;
          chk(tid == ref_tid[s] && issue == ex, "R8 mask idle slot",
              {tid, issue}, {ref_tid[s], ex});
          step();
        end
      end
      en = 8'hFF;
    end

    do_reset(0);
    for (int s = 0; s < 48; s++) begin
      if (s == 5) mode = 3'd2;
      if (s == 20) mode = 3'd6;
      if (s == 24) mode = 3'd2;
      #1;
      if (s < 16) chk((tid == 3'd0) == (s % 2 == 0), "R10 old table kept", tid, s % 2);
      else chk(tid == 3'(s % 8), "R10 new table at frame start", tid, s % 8);
      step();
    end

    do_reset(2);
    for (int s = 0; s < 32; s++) begin
      if (s == 15) mode = 3'd0;
      #1;
      if (s <= 15) chk(tid == 3'(s % 8), "R10 last slot", tid, s % 8);
      else if (s % 2 == 0) chk(tid == 3'd0, "R10 switch at boundary", tid, 0);
      step();
    end

    do_reset(2);
    for (int s = 0; s < 9; s++) step();
    do_reset(2);
    for (int s = 0; s < 20; s++) begin
      chk(tid == 3'(s % 8), "R1 count after mid-frame reset", tid, s % 8);
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule